// File: doc/BRIEF.md
# Four-Phase One-Hot Quad-Wire Link Codec

This block joins two ends of a point-to-point channel that carries data as one-hot codewords on four wires. The sending end takes words from a valid/ready stream and splits each into 2-bit symbols. Each symbol goes out as a single raised wire, followed by an all-low spacer, under a return-to-zero four-phase handshake with one acknowledge wire. The receiving end decides that a codeword is present when any wire is high. It splits the wires into a pair of true/false rails per bit, takes the symbol from the true rails, and raises the acknowledge. It then rebuilds the word and presents it on a valid/ready output stream.

Both ends are synchronous and sample the link on a common clock. The two ends are separate port groups on the top module, so the wires can be routed or looped back outside. The receiver can optionally put a register stage on the incoming wires. It reports any sample with more than one wire high as a protocol error and never acknowledges such a pattern.

Top module: `quad_link`

## Requirements
- R1: The transmitter drives symbol 00 as wires 4'b0001, 01 as 4'b0010, 10 as 4'b0100 and 11 as 4'b1000 (bit i of `tx_wires` is wire i). At most one transmit wire is ever high.
- R2: A word of DATA_W bits is sent as DATA_W/2 codewords, bits [1:0] first and the most significant pair last.
- R3: After a codeword the transmitter holds it until the acknowledge is seen high, then drops to the all-low spacer. It raises a new codeword only after it has sampled the acknowledge low.
- R4: The receiver raises `rx_ack` once for each valid codeword it takes, and lowers it only after it has seen the all-low spacer.
- R5: `snk_valid` rises after the last symbol of a word, `snk_data` equals the word that was sent, and valid and data hold unchanged while `snk_ready` is low. Words come out in the order they went in.
- R6: When more than one receive wire is high, `rx_err` is high (one cycle after the pattern reaches the decoder). The pattern is not acknowledged and produces no output word.
- R7: While `rst_n` is low at a clock edge, the transmit wires go to the spacer, `rx_ack`, `rx_err` and `snk_valid` go low, and the transmitter is idle.
- R8: `src_ready` is high only when the transmitter is idle with its wires at the spacer and the acknowledge low.
- R9: The receiver gets each symbol bit from a true/false rail pair. For bit 0 the false rail is wire0|wire2 and the true rail is wire1|wire3; for bit 1 the false rail is wire0|wire1 and the true rail is wire2|wire3. The symbol is taken only when the OR of all four wires is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ends |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Word to send is valid |
| src_ready | output | 1 | Transmitter accepts the word |
| src_data | input | DATA_W | Word to send |
| tx_wires | output | 4 | Outgoing one-hot codeword or spacer |
| tx_ack | input | 1 | Acknowledge returned from the far receiver |
| rx_wires | input | 4 | Incoming codeword or spacer |
| rx_ack | output | 1 | Acknowledge driven to the far transmitter |
| snk_valid | output | 1 | Rebuilt word is valid |
| snk_ready | input | 1 | Consumer takes the word |
| snk_data | output | DATA_W | Rebuilt word |
| rx_err | output | 1 | More than one receive wire was high |

## Verification
The bench builds the codec with DATA_W = 6 and the input register stage on. A word is then three symbols, so a word has a middle symbol as well as first and last ones, and the receiver's assembly sees an odd symbol count. The extra wire register lengthens the handshake loop by one cycle. Random consumer stalls then land on the last symbol of a word while earlier symbols are still flowing, which exercises the holdback of the final acknowledge. The bench also overrides the looped-back wires with two- and three-hot patterns to reach the error path, and then sends a further word to show that the link recovers.

// File: rtl/quad_link_pkg.sv
`timescale 1ns/1ps
package quad_link_pkg;

   typedef logic [3:0] quad_t;

   typedef struct packed {
      logic t;
      logic f;
   } rail_t;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_CODE  = 2'd1,
      TX_SPACE = 2'd2
   } tx_state_t;

   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/quad_onehot_enc.sv
`timescale 1ns/1ps
module quad_onehot_enc
   import quad_link_pkg::*;
(
   input  logic [1:0] sym,
   output quad_t      code
);
   always_comb begin
      code = '0;
      code[sym] = 1'b1;
   end
endmodule

// File: rtl/quad_rail_dec.sv
`timescale 1ns/1ps
module quad_rail_dec
   import quad_link_pkg::*;
(
   input  quad_t      wires,
   output logic       complete,
   output logic       multi,
   output logic [1:0] sym
);
   rail_t rail [2];

   for (genvar b = 0; b < 2; b++) begin : g_rail
      always_comb begin
         rail[b] = '0;
         for (int j = 0; j < 4; j++) begin
            if (((j >> b) & 1) != 0) rail[b].t = rail[b].t | wires[j];
            else                     rail[b].f = rail[b].f | wires[j];
         end
      end
      assign sym[b] = rail[b].t;
   end

   assign complete = |wires;
   // two or more wires always set both rails of at least one bit
   assign multi    = (rail[0].t & rail[0].f) | (rail[1].t & rail[1].f);
endmodule

// File: rtl/quad_tx.sv
`timescale 1ns/1ps
module quad_tx
   import quad_link_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_valid,
   output logic              src_ready,
   input  logic [DATA_W-1:0] src_data,
   output quad_t             wires_o,
   input  logic              ack_i
);
   localparam int NSYM = DATA_W / 2;
   localparam int CW   = cnt_width(NSYM);

   tx_state_t         st_q;
   quad_t             wires_q;
   quad_t             code_nxt;
   logic [DATA_W-1:0] sh_q;
   logic [CW-1:0]     left_q;
   logic [1:0]        sym_nxt;

   assign sym_nxt   = (st_q == TX_IDLE) ? src_data[1:0] : sh_q[1:0];
   assign src_ready = (st_q == TX_IDLE) && !ack_i;
   assign wires_o   = wires_q;

   quad_onehot_enc u_enc (.sym(sym_nxt), .code(code_nxt));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= TX_IDLE;
         wires_q <= '0;
         sh_q    <= '0;
         left_q  <= '0;
      end else begin
         case (st_q)
            TX_IDLE: begin
               if (src_valid && src_ready) begin
                  wires_q <= code_nxt;
                  sh_q    <= src_data >> 2;
                  left_q  <= CW'(NSYM - 1);
                  st_q    <= TX_CODE;
               end
            end
            TX_CODE: begin
               if (ack_i) begin
                  wires_q <= '0;
                  st_q    <= TX_SPACE;
               end
            end
            TX_SPACE: begin
               if (!ack_i) begin
                  if (left_q == '0) begin
                     st_q <= TX_IDLE;
                  end else begin
                     wires_q <= code_nxt;
                     sh_q    <= sh_q >> 2;
                     left_q  <= left_q - 1'b1;
                     st_q    <= TX_CODE;
                  end
               end
            end
            default: st_q <= TX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/quad_rx.sv
`timescale 1ns/1ps
module quad_rx
   import quad_link_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit RX_IN_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  quad_t             wires_i,
   output logic              ack_o,
   output logic              err_o,
   output logic              snk_valid,
   input  logic              snk_ready,
   output logic [DATA_W-1:0] snk_data
);
   localparam int NSYM = DATA_W / 2;
   localparam int CW   = cnt_width(NSYM);

   quad_t             wires_s;
   logic              complete, multi;
   logic [1:0]        sym;
   logic              ack_q, err_q, oval_q;
   logic [DATA_W-1:0] odata_q;
   logic [CW-1:0]     cnt_q;
   logic              last, slot_free, take;
   logic [DATA_W-1:0] word_full;

   if (RX_IN_REG) begin : g_in_reg
      quad_t in_q;
      always_ff @(posedge clk) begin
         if (!rst_n) in_q <= '0;
         else        in_q <= wires_i;
      end
      assign wires_s = in_q;
   end else begin : g_in_direct
      assign wires_s = wires_i;
   end

   quad_rail_dec u_dec (
      .wires    (wires_s),
      .complete (complete),
      .multi    (multi),
      .sym      (sym)
   );

   assign last      = (cnt_q == CW'(NSYM - 1));
   assign slot_free = !oval_q || snk_ready;
   assign take      = !ack_q && complete && !multi && (!last || slot_free);

   if (NSYM == 1) begin : g_one_sym
      assign word_full = sym;
   end else begin : g_multi_sym
      logic [DATA_W-3:0] part_q;
      always_ff @(posedge clk) begin
         if (!rst_n)    part_q <= '0;
         else if (take) part_q <= word_full[DATA_W-1:2];
      end
      assign word_full = {sym, part_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         err_q   <= 1'b0;
         oval_q  <= 1'b0;
         odata_q <= '0;
         cnt_q   <= '0;
      end else begin
         err_q <= multi;
         if (take)                   ack_q <= 1'b1;
         else if (ack_q && !complete) ack_q <= 1'b0;
         if (take) cnt_q <= last ? '0 : cnt_q + 1'b1;
         if (take && last) begin
            oval_q  <= 1'b1;
            odata_q <= word_full;
         end else if (snk_ready) begin
            oval_q  <= 1'b0;
         end
      end
   end

   assign ack_o     = ack_q;
   assign err_o     = err_q;
   assign snk_valid = oval_q;
   assign snk_data  = odata_q;
endmodule

// File: rtl/quad_link.sv
`timescale 1ns/1ps
module quad_link
   import quad_link_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit RX_IN_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_valid,
   output logic              src_ready,
   input  logic [DATA_W-1:0] src_data,
   output logic [3:0]        tx_wires,
   input  logic              tx_ack,
   input  logic [3:0]        rx_wires,
   output logic              rx_ack,
   output logic              snk_valid,
   input  logic              snk_ready,
   output logic [DATA_W-1:0] snk_data,
   output logic              rx_err
);
   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("quad_link: DATA_W must be even and at least 2");
   end

   quad_tx #(.DATA_W(DATA_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_valid (src_valid),
      .src_ready (src_ready),
      .src_data  (src_data),
      .wires_o   (tx_wires),
      .ack_i     (tx_ack)
   );

   quad_rx #(.DATA_W(DATA_W), .RX_IN_REG(RX_IN_REG)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .wires_i   (rx_wires),
      .ack_o     (rx_ack),
      .err_o     (rx_err),
      .snk_valid (snk_valid),
      .snk_ready (snk_ready),
      .snk_data  (snk_data)
   );
endmodule

// File: rtl/quad_link_chk.sv
`timescale 1ns/1ps
module quad_link_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              src_ready,
   input logic [3:0]        tx_wires,
   input logic              tx_ack,
   input logic              rx_ack,
   input logic              rx_err,
   input logic              snk_valid,
   input logic              snk_ready,
   input logic [DATA_W-1:0] snk_data
);
   AST_TX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_wires)); // R1

   AST_TX_WAIT_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wires != 4'b0 && $past(tx_wires) == 4'b0) |-> !$past(tx_ack)); // R3

   AST_TX_HOLD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wires != 4'b0 && !tx_ack) |=> $stable(tx_wires)); // R3

   AST_RX_NO_ACK_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ack) |-> !rx_err); // R6

   AST_SNK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data))); // R5

   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      src_ready |-> (tx_wires == 4'b0 && !tx_ack)); // R8
endmodule

bind quad_link quad_link_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_ready (src_ready),
   .tx_wires  (tx_wires),
   .tx_ack    (tx_ack),
   .rx_ack    (rx_ack),
   .rx_err    (rx_err),
   .snk_valid (snk_valid),
   .snk_ready (snk_ready),
   .snk_data  (snk_data)
);

// File: tb/quad_link_tb.sv
`timescale 1ns/1ps
module quad_link_tb;
   localparam int W    = 6;
   localparam int NSYM = W / 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         src_valid = 1'b0;
   logic         src_ready;
   logic [W-1:0] src_data = '0;
   logic [3:0]   tx_wires;
   logic         tx_ack;
   logic [3:0]   rx_wires;
   logic         rx_ack;
   logic         snk_valid;
   logic         snk_ready = 1'b0;
   logic [W-1:0] snk_data;
   logic         rx_err;
   logic         inj_en = 1'b0;
   logic [3:0]   inj_val = '0;

   always #4 clk = ~clk;

   assign tx_ack   = rx_ack;
   assign rx_wires = inj_en ? inj_val : tx_wires;

   quad_link #(.DATA_W(W), .RX_IN_REG(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
      .tx_wires(tx_wires), .tx_ack(tx_ack),
      .rx_wires(rx_wires), .rx_ack(rx_ack),
      .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data),
      .rx_err(rx_err)
   );

   int n_chk = 0, n_fail = 0;
   int n_codes = 0, n_ack_rise = 0, n_words_out = 0;
   bit done = 1'b0, mon_on = 1'b0, traffic = 1'b1, fired_src = 1'b0;
   logic [W-1:0] sent_q[$];
   logic [W-1:0] txw_q[$];
   logic [W-1:0] cur_tx;
   bit           have_cur = 1'b0;
   int           sym_i = 0;
   logic [3:0]   prev_w = '0, prev_rxw = '0;
   logic         prev_ack = 1'b0, prev_sv = 1'b0, prev_sr = 1'b0;
   logic [W-1:0] prev_sd = '0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   // cycle monitor: reference model of the link seen at the ports
   always @(negedge clk) begin
      if (mon_on) begin
         fired_src = src_valid && src_ready;
         chk($onehot0(tx_wires), "R1 onehot", tx_wires, 0);
         if (src_ready) chk(tx_wires == 4'b0 && !tx_ack, "R8 ready idle", {tx_wires, tx_ack}, 0);
         if (prev_w == 4'b0 && tx_wires != 4'b0) begin
            if (!have_cur) begin
               cur_tx   = txw_q.pop_front();
               have_cur = 1'b1;
               sym_i    = 0;
            end
            chk(tx_wires == (4'b1 << cur_tx[2*sym_i +: 2]), "R1 R2 codeword",
                tx_wires, 4'b1 << cur_tx[2*sym_i +: 2]);
            chk(!prev_ack, "R3 new code after ack low", prev_ack, 0);
            n_codes++;
            sym_i++;
            if (sym_i == NSYM) have_cur = 1'b0;
         end
         if (prev_w != 4'b0 && tx_wires != prev_w) begin
            chk(tx_wires == 4'b0, "R3 spacer", tx_wires, 0);
            chk(prev_ack, "R3 spacer after ack", prev_ack, 1);
         end
         if (rx_ack && !prev_ack) begin
            n_ack_rise++;
            chk($onehot(prev_rxw), "R4 ack rises on codeword", prev_rxw, 0);
         end
         if (!rx_ack && prev_ack) chk(prev_rxw == 4'b0, "R4 ack falls after spacer", prev_rxw, 0);
         if (traffic) chk(!rx_err, "R6 no error in traffic", rx_err, 0);
         if (prev_sv && !prev_sr)
            chk(snk_valid && snk_data == prev_sd, "R5 hold", {snk_valid, snk_data}, {1'b1, prev_sd});
         if (fired_src) begin
            sent_q.push_back(src_data);
            txw_q.push_back(src_data);
         end
         if (snk_valid && snk_ready) begin
            if (sent_q.size() == 0) begin
               chk(1'b0, "R5 unexpected word", snk_data, 0);
            end else begin
               logic [W-1:0] e;
               e = sent_q.pop_front();
               chk(snk_data == e, "R5 R9 word", snk_data, e);
            end
            n_words_out++;
         end
         prev_w   = tx_wires;
         prev_rxw = rx_wires;
         prev_ack = rx_ack;
         prev_sv  = snk_valid;
         prev_sr  = snk_ready;
         prev_sd  = snk_data;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         finish_run();
      end
   end

   task automatic drive_cycles(input int n, input int pv, input int pr);
      for (int c = 0; c < n; c++) begin
         @(posedge clk); #1;
         if (fired_src || !src_valid) begin
            int r;
            r = $urandom % 8;
            src_valid = ($urandom % 100) < pv;
            src_data  = (r == 0) ? '0 : (r == 1) ? '1 : W'($urandom);
         end
         snk_ready = ($urandom % 100) < pr;
      end
   endtask

   task automatic drain();
      int guard = 0;
      @(posedge clk); #1;
      if (!fired_src) src_valid = 1'b0;
      @(posedge clk); #1;
      src_valid = 1'b0;
      snk_ready = 1'b1;
      while ((sent_q.size() != 0 || !src_ready || have_cur) && guard < 2000) begin
         @(posedge clk); #1;
         guard++;
      end
      repeat (4) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R7 reset state
      chk(tx_wires == 4'b0, "R7 wires spacer", tx_wires, 0);
      chk(!rx_ack, "R7 ack low", rx_ack, 0);
      chk(!snk_valid, "R7 no output", snk_valid, 0);
      chk(!rx_err, "R7 no error", rx_err, 0);
      chk(src_ready, "R7 R8 ready idle", src_ready, 1);
      @(posedge clk); #1;
      rst_n = 1'b1;
      mon_on = 1'b1;

      drive_cycles(3000, 70, 50);   // random back-pressure
      drive_cycles(1500, 100, 100); // streaming
      drive_cycles(1500, 60, 15);   // heavy stall
      drain();
      chk(sent_q.size() == 0, "R5 all words delivered", sent_q.size(), 0);
      chk(n_ack_rise == n_codes, "R4 one ack per codeword", n_ack_rise, n_codes);
      chk(n_codes == NSYM * n_words_out, "R2 symbols per word", n_codes, NSYM * n_words_out);

      // R6 error injection on an idle link
      traffic = 1'b0;
      inj_val = 4'b0101;
      inj_en  = 1'b1;
      repeat (5) @(negedge clk);
      chk(rx_err, "R6 two-hot flagged", rx_err, 1);
      chk(!rx_ack, "R6 two-hot not acked", rx_ack, 0);
      chk(!snk_valid, "R6 no word", snk_valid, 0);
      @(posedge clk); #1;
      inj_val = 4'b1110;
      repeat (5) @(negedge clk);
      chk(rx_err, "R6 three-hot flagged", rx_err, 1);
      chk(!rx_ack, "R6 three-hot not acked", rx_ack, 0);
      @(posedge clk); #1;
      inj_val = 4'b0000;
      repeat (3) @(posedge clk); #1;
      inj_en = 1'b0;
      repeat (3) @(negedge clk);
      chk(!rx_err, "R6 error clears", rx_err, 1'b0);
      chk(!rx_ack, "R4 ack idle", rx_ack, 0);
      traffic = 1'b1;

      // link still works afterwards
      drive_cycles(200, 80, 70);
      drain();
      chk(sent_q.size() == 0, "R5 recovery words", sent_q.size(), 0);

      done = 1'b1;
      finish_run();
   end
endmodule